// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog counter whose configuration can only be changed after a two-step unlock handshake on its register bus. Software writes a first key value to one key register and then a second key value to another. The very next single write to a protected register (control, match limit or status) then takes effect. Every further protected write needs the whole handshake again.

Once the count-enable bit is set, the counter advances on each cycle where the counter tick input is high. When the count equals the programmed match limit, the timeout status flag is set and the counter restarts from zero. If the reset-enable bit is also set, the same match raises a system reset request. That request stays high until the block's own reset. The counter value and the status can be read at any time without unlocking.

Top module: `keyprot_wdt`

## Requirements
- R1: After reset, the control register, match limit, counter, timeout flag and reset request all read 0.
- R2: Unlocking takes two writes. First 0xBABA is written to the first key register (address 4), then 0xEB10 to the second key register (address 5). After that, the next write to a protected register (address 0 control, address 1 match limit, address 2 status) takes effect.
- R3: A completed unlock allows exactly one protected write. Any protected write after it, without a new handshake, is ignored.
- R4: Several cases leave the block locked. A protected write without a completed handshake is ignored. The second key without the first does not unlock. Any other bus write between the first and second key cancels the partial unlock.
- R5: Control bit 0 enables counting. With it set, the counter (read at address 3 without unlocking) advances by one on each cycle with the tick input high. With the bit clear, or the tick low, the counter holds.
- R6: An enabled tick that finds the counter equal to the match limit sets the timeout flag in the next cycle and returns the counter to 0. With limit L, the timeout comes on the (L+1)th enabled tick.
- R7: Control bit 1 makes a match also raise the reset request. With only bit 0 set, a match sets the flag but raises no reset request.
- R8: Once raised, the reset request stays high, even after the status is cleared, until the block reset.
- R9: An unlocked status write with data bit 0 equal to 0 clears the timeout flag. An unlocked status write with data bit 0 equal to 1 leaves the flag unchanged. A match in the same cycle as a clear wins, and the flag stays set.
- R10: Read map: address 0 gives control in bits [1:0]; address 1 gives the match limit; address 2 gives the flag in bit 0 and the reset request in bit 1; address 3 gives the counter. The key registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous block reset |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 3 | Register word address |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data for busAddr (combinational) |
| cntTick | input | 1 | Counter clock enable |
| timeoutFlag | output | 1 | Timeout status flag |
| rstReq | output | 1 | Sticky system reset request |

## Verification
The two functions that can land in the same cycle are a match event and an unlocked status-clear write. The bench brings the flag high with an earlier timeout. It then runs the counter up to one below the match point, unlocks, and issues the clear write with the tick held high in that same cycle. The flag must still read 1 afterwards, showing that the match won. A later clear with the tick low must then bring it to 0.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int ADDR_W = 3;

  // register word addresses
  localparam logic [ADDR_W-1:0] ADR_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_LIMIT  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_STATUS = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_COUNT  = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_KEY1   = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_KEY2   = 3'd5;

  typedef enum logic [1:0] {
    LK_LOCKED = 2'd0,
    LK_HALF   = 2'd1,
    LK_OPEN   = 2'd2
  } lockState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic wrCtrl;
    logic wrLimit;
    logic wrStatus;
  } wdtStb_t;
endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] KEY_A = 16'hBABA,
  parameter logic [DATA_W-1:0] KEY_B = 16'hEB10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output wdtStb_t           stb
);
  lockState_t lockQ, lockD;
  logic isKeyA, isKeyB, isProt;

  assign isKeyA = (busAddr == ADR_KEY1) && (busWdata == KEY_A);
  assign isKeyB = (busAddr == ADR_KEY2) && (busWdata == KEY_B);
  assign isProt = (busAddr == ADR_CTRL) || (busAddr == ADR_LIMIT) ||
                  (busAddr == ADR_STATUS);

  always_comb begin
    lockD = lockQ;
    if (busWe) begin
      if (isKeyA)                        lockD = LK_HALF;
      else if (lockQ == LK_HALF && isKeyB) lockD = LK_OPEN;
      else                               lockD = LK_LOCKED;
    end
  end

  always_comb begin
    stb = '0;
    if (busWe && lockQ == LK_OPEN && isProt) begin
      stb.wrCtrl   = (busAddr == ADR_CTRL);
      stb.wrLimit  = (busAddr == ADR_LIMIT);
      stb.wrStatus = (busAddr == ADR_STATUS);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) lockQ <= LK_LOCKED;
    else       lockQ <= lockD;
  end
endmodule

// File: rtl/wdt_dp.sv
module wdt_dp
  import wdt_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  wdtStb_t           stb,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              cntTick,
  output logic [DATA_W-1:0] busRdata,
  output logic              timeoutFlag,
  output logic              rstReq
);
  localparam int RD_W = (CNT_W > DATA_W) ? DATA_W : CNT_W;

  logic [1:0]       ctrlQ;
  logic [CNT_W-1:0] limitQ, countQ;
  logic             flagQ, rstReqQ;
  logic             step, hit;

  assign step = ctrlQ[0] && cntTick;
  assign hit  = step && (countQ == limitQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ   <= '0;
      limitQ  <= '0;
      countQ  <= '0;
      flagQ   <= 1'b0;
      rstReqQ <= 1'b0;
    end else begin
      if (stb.wrCtrl)  ctrlQ  <= busWdata[1:0];
      if (stb.wrLimit) limitQ <= CNT_W'(busWdata);
      if (step)        countQ <= hit ? '0 : countQ + 1'b1;
      if (hit)                               flagQ <= 1'b1;
      else if (stb.wrStatus && !busWdata[0]) flagQ <= 1'b0;
      if (hit && ctrlQ[1]) rstReqQ <= 1'b1;
    end
  end

  always_comb begin
    busRdata = '0;
    unique case (busAddr)
      ADR_CTRL:   busRdata[1:0] = ctrlQ;
      ADR_LIMIT:  busRdata[RD_W-1:0] = limitQ[RD_W-1:0];
      ADR_STATUS: busRdata[1:0] = {rstReqQ, flagQ};
      ADR_COUNT:  busRdata[RD_W-1:0] = countQ[RD_W-1:0];
      default:    busRdata = '0;
    endcase
  end

  assign timeoutFlag = flagQ;
  assign rstReq      = rstReqQ;
endmodule

// File: rtl/keyprot_wdt.sv
module keyprot_wdt
  import wdt_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter logic [DATA_W-1:0] KEY_A = 16'hBABA,
  parameter logic [DATA_W-1:0] KEY_B = 16'hEB10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [2:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              cntTick,
  output logic              timeoutFlag,
  output logic              rstReq
);
  wdtStb_t stb;
  logic [2:0] protStb;

  wdt_ctrl #(.DATA_W(DATA_W), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .stb(stb)
  );

  wdt_dp #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .busWdata(busWdata),
    .busAddr(busAddr), .cntTick(cntTick), .busRdata(busRdata),
    .timeoutFlag(timeoutFlag), .rstReq(rstReq)
  );

  assign protStb = {stb.wrCtrl, stb.wrLimit, stb.wrStatus};
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker (
  input logic       clk,
  input logic       rstN,
  input logic       busWe,
  input logic       cntTick,
  input logic [2:0] protStb,
  input logic       timeoutFlag,
  input logic       rstReq
);
  // R3: an unlock is spent by one protected write
  a_r3_single_write: assert property (@(posedge clk) disable iff (!rstN)
    (protStb != 3'b000) |=> (protStb == 3'b000));

  // R4: protected strobes only come from a bus write
  a_r4_stb_needs_write: assert property (@(posedge clk) disable iff (!rstN)
    (protStb != 3'b000) |-> busWe);

  // R6: the flag rises only after a tick
  a_r6_flag_after_tick: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutFlag) |-> $past(cntTick));

  // R7: a reset request comes with a timeout
  a_r7_req_with_flag: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstReq) |-> timeoutFlag);

  // R8: the request is sticky
  a_r8_req_sticky: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> rstReq);

  // R9: the flag falls only through a status write
  a_r9_clear_by_write: assert property (@(posedge clk) disable iff (!rstN)
    $fell(timeoutFlag) |-> $past(protStb[0]));
endmodule

bind keyprot_wdt wdt_checker u_chk (
  .clk(clk), .rstN(rstN), .busWe(busWe), .cntTick(cntTick),
  .protStb(protStb), .timeoutFlag(timeoutFlag), .rstReq(rstReq)
);

// File: tb/keyprot_wdt_test.sv
module keyprot_wdt_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWe = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic        cntTick = 1'b0;
  logic        timeoutFlag, rstReq;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  keyprot_wdt uut (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .cntTick(cntTick),
    .timeoutFlag(timeoutFlag), .rstReq(rstReq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic unlock();
    wr(3'd4, 16'hBABA);
    wr(3'd5, 16'hEB10);
  endtask

  task automatic ticks(int n);
    @(negedge clk);
    cntTick = 1'b1;
    repeat (n) @(negedge clk);
    cntTick = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk); rstN = 1'b1;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    doReset();
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      chk("R1 reset value", v, 0);
    end
    chk("R1 flag", timeoutFlag, 0);
    chk("R1 rstReq", rstReq, 0);
  endtask

  task automatic t_locked();
    logic [15:0] v;
    wr(3'd1, 16'h0055);
    rd(3'd1, v); chk("R4 locked write ignored", v, 0);
    wr(3'd5, 16'hEB10); wr(3'd1, 16'h0055);
    rd(3'd1, v); chk("R4 second key alone", v, 0);
    wr(3'd4, 16'hBABA); wr(3'd3, 16'h0000); wr(3'd5, 16'hEB10);
    wr(3'd1, 16'h0055);
    rd(3'd1, v); chk("R4 cancel between keys", v, 0);
  endtask

  task automatic t_unlock();
    logic [15:0] v;
    unlock(); wr(3'd1, 16'h0003);
    rd(3'd1, v); chk("R2 unlocked write", v, 16'h0003);
    wr(3'd1, 16'h0009);
    rd(3'd1, v); chk("R3 second write ignored", v, 16'h0003);
    rd(3'd4, v); chk("R10 key reads zero", v, 0);
  endtask

  task automatic t_count();
    logic [15:0] v;
    ticks(2);
    rd(3'd3, v); chk("R5 no count when disabled", v, 0);
    unlock(); wr(3'd0, 16'h0001);
    rd(3'd0, v); chk("R10 ctrl read", v, 1);
    ticks(3);
    rd(3'd3, v); chk("R5 count three", v, 3);
    chk("R6 no flag before match", timeoutFlag, 0);
    repeat (3) @(negedge clk);
    rd(3'd3, v); chk("R5 hold without tick", v, 3);
    ticks(1);
    chk("R6 flag at match", timeoutFlag, 1);
    rd(3'd3, v); chk("R6 counter restarts", v, 0);
    chk("R7 no request with bit0 only", rstReq, 0);
    rd(3'd2, v); chk("R10 status read", v, 16'h0001);
  endtask

  task automatic t_clear();
    logic [15:0] v;
    unlock(); wr(3'd2, 16'h0001);
    chk("R9 write of 1 keeps flag", timeoutFlag, 1);
    ticks(3);
    unlock();
    @(negedge clk);
    busWe = 1'b1; busAddr = 3'd2; busWdata = 16'h0000; cntTick = 1'b1;
    @(negedge clk);
    busWe = 1'b0; cntTick = 1'b0;
    chk("R9 match beats clear", timeoutFlag, 1);
    unlock(); wr(3'd2, 16'h0000);
    chk("R9 clear", timeoutFlag, 0);
    rd(3'd3, v); chk("R6 count after collision", v, 0);
  endtask

  task automatic t_resetReq();
    unlock(); wr(3'd0, 16'h0003);
    ticks(3);
    chk("R7 no request early", rstReq, 0);
    ticks(1);
    chk("R7 request at match", rstReq, 1);
    unlock(); wr(3'd2, 16'h0000);
    chk("R8 flag cleared", timeoutFlag, 0);
    chk("R8 request held", rstReq, 1);
    repeat (5) @(negedge clk);
    chk("R8 request still held", rstReq, 1);
    doReset();
    chk("R8 reset clears request", rstReq, 0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_locked();
        t_unlock();
        t_count();
        t_clear();
        t_resetReq();
      end
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule